// File: doc/BRIEF.md
# Extended Match Timer Group

This block holds eight timer channels. Each channel pairs a match value with a control word and can either run a counter of its own or follow the counter of a lead channel. Each counter advances on a per-source tick-enable input, so the clock dividers stay outside the block. A channel fires when the counter it watches steps onto its match value. When a channel fires it may clear that counter, may stay armed for the next pass, and raises a status flag if its enable bit is set. The status flags of all eight channels combine into a single interrupt line.

Software reaches the block through a simple word-addressed register port. Writes take effect at the next clock edge. Read data appears one cycle after the read strobe. Channels 5 and 7 can latch the count of the channel just below them whenever their own count is read, so that a pair of counters can be sampled together.

Top module: `xtmr_grp`

## Requirements
- R1: After reset every counter reads 0, every control word reads 0, enable and status read 0, `irq` is low, and every counter stays stopped until a control write gives it a clock source.
- R2: A running counter adds one in each cycle in which its latched source's `tick_en` bit is high. The source comes from control bits [2:0]. On channels 4 to 7, control bit 8 forces source 0. A source whose bit in `SRC_MASK` is 0 (by default sources 5, 6 and 7) leaves the counter stopped.
- R3: With control bit 7 set, a channel watches its own counter. With bit 7 clear, it watches counter 0 (channels 0 to 3), counter 4 (channels 4 and 5) or counter 6 (channels 6 and 7). A control write latches a new source into that channel's counter only when bit 7 is set or the channel is 0, 4 or 6.
- R4: When control bit 3 is set, the tick that would carry the watched counter onto the match value loads 0 into that counter instead.
- R5: A channel fires when its watched counter steps onto its match value while the channel is armed. Writing the match register arms it. Control bit 6 keeps it armed after a hit. Without bit 6 it fires only once, and until it is re-armed it neither fires nor clears the counter.
- R6: A hit sets status bit 4+n only if enable bit 4+n is set. Enable is at word 24 and status at word 25, and bits [11:4] map to channels 0 to 7. Writing a one to a status bit clears that bit and no other.
- R7: `irq` is high exactly while any status bit [11:4] is set.
- R8: Reading channel 5's or channel 7's count (words 13 and 15) while that channel's control bit 9 is set copies counter 4 or counter 6 into the snapshot word (word 26). The snapshot word holds its value until the next such read.
- R9: Control words are at words 16 to 23. Channels 0 to 3 keep only bits [7:0] of a written value, and channels 4 to 7 keep bits [9:0].
- R10: Match values are at words 0 to 7 and counts at words 8 to 15. Writing a count word loads that counter directly, and a read of a count word returns the counter of that channel number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 8 | One count-enable per clock source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Combined channel interrupt |

## Verification
The properties assume that a counter changes only because of a tick on its source or a bus write, and that only a read strobe can move the snapshot. They also assume that read and write strobes never share a cycle and that all inputs are known once reset is released. The stimulus meets these assumptions: it drives every input at falling edges, issues one bus access at a time, and keeps `tick_en` at zero outside its deliberate pulses. Because of this, each expected count equals the number of pulse cycles, adjusted only by the clear-on-match rule.

// File: rtl/xtmr_pkg.sv
package xtmr_pkg;
  localparam int NCH  = 8;
  localparam int NSRC = 8;
  localparam int AW   = 5;
  localparam int DW   = 32;
  localparam int CW   = 10;
  localparam int EV_LSB = 4;

  // control word fields
  localparam int CB_CLR  = 3;
  localparam int CB_PER  = 6;
  localparam int CB_OWN  = 7;
  localparam int CB_F0   = 8;
  localparam int CB_SNAP = 9;

  // address banks (addr[4:3]) and single words
  localparam logic [1:0] BK_MATCH = 2'd0;
  localparam logic [1:0] BK_CNT   = 2'd1;
  localparam logic [1:0] BK_CTRL  = 2'd2;
  localparam logic [AW-1:0] A_EN   = 5'd24;
  localparam logic [AW-1:0] A_STAT = 5'd25;
  localparam logic [AW-1:0] A_SNAP = 5'd26;

  typedef logic [CW-1:0] ctrl_t;

  // counter that a non-owning channel follows
  function automatic int lead_of(input int n);
    if (n < 4) return 0;
    else if (n < 6) return 4;
    else return 6;
  endfunction
endpackage

// File: rtl/xtmr_cnt.sv
module xtmr_cnt #(
  parameter int W = 32,
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] SRC_MASK = '1,
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_src,
  input  logic [NSRC-1:0] tick_en,
  input  logic            ld,
  input  logic [W-1:0]    ld_val,
  input  logic            zero_req,
  output logic [W-1:0]    cnt,
  output logic            step
);
  logic [SW-1:0] src_q;
  logic          run_q;
  logic [W-1:0]  cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    step   = run_q & tick_en[src_q];
    cnt_en = ld | step;
    if (ld)            cnt_d = ld_val;
    else if (zero_req) cnt_d = '0;
    else               cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (cfg_we) begin
        src_q <= cfg_src;
        run_q <= SRC_MASK[cfg_src];
      end
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/xtmr_chan.sv
module xtmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_in,
  input  logic         step_in,
  input  logic         ld_in,
  input  logic         match_we,
  input  logic [W-1:0] match_wd,
  input  logic         periodic,
  output logic [W-1:0] match_val,
  output logic         hit
);
  logic [W-1:0] match_q;
  logic         armed_q, armed_d;

  always_comb begin
    hit = armed_q & step_in & ~ld_in & ((cnt_in + W'(1)) == match_q);
    if (match_we)             armed_d = 1'b1;
    else if (hit && !periodic) armed_d = 1'b0;
    else                      armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      armed_q <= 1'b0;
    end else begin
      if (match_we) match_q <= match_wd;
      armed_q <= armed_d;
    end
  end

  assign match_val = match_q;
endmodule

// File: rtl/xtmr_grp.sv
module xtmr_grp
  import xtmr_pkg::*;
#(
  parameter int W = 32,
  parameter logic [NSRC-1:0] SRC_MASK = 8'h1F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_en,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam int SW = $clog2(NSRC);

  logic [1:0] bank;
  logic [2:0] idx;
  assign bank = addr[4:3];
  assign idx  = addr[2:0];

  logic [NCH-1:0][W-1:0] cnt_arr, match_arr;
  logic [NCH-1:0][CW-1:0] ctrl_q;
  logic [NCH-1:0] step_arr, ld_arr, cfg_we, zero_req, hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LD = lead_of(c);
    localparam bit UPPER = (c >= NCH/2);
    localparam logic [2:0] CI = 3'(c);

    logic          ctrl_we, use_own;
    ctrl_t         ctrl_wd;
    logic [SW-1:0] src_sel;

    always_comb begin
      ctrl_we   = wr_en && bank == BK_CTRL && idx == CI;
      ld_arr[c] = wr_en && bank == BK_CNT && idx == CI;
      cfg_we[c] = ctrl_we && (wdata[CB_OWN] || LD == c);
      src_sel   = (UPPER && wdata[CB_F0]) ? '0 : wdata[SW-1:0];
      ctrl_wd   = UPPER ? wdata[CW-1:0] : {2'b00, wdata[7:0]};
      use_own   = ctrl_q[c][CB_OWN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q[c] <= '0;
      else if (ctrl_we) ctrl_q[c] <= ctrl_wd;
    end

    xtmr_cnt #(.W(W), .NSRC(NSRC), .SRC_MASK(SRC_MASK)) cnt_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[c]), .cfg_src(src_sel),
      .tick_en(tick_en), .ld(ld_arr[c]), .ld_val(wdata[W-1:0]),
      .zero_req(zero_req[c]), .cnt(cnt_arr[c]), .step(step_arr[c])
    );

    xtmr_chan #(.W(W)) chan_i (
      .clk(clk), .rst_n(rst_n),
      .cnt_in (use_own ? cnt_arr[c]  : cnt_arr[LD]),
      .step_in(use_own ? step_arr[c] : step_arr[LD]),
      .ld_in  (use_own ? ld_arr[c]   : ld_arr[LD]),
      .match_we(wr_en && bank == BK_MATCH && idx == CI),
      .match_wd(wdata[W-1:0]), .periodic(ctrl_q[c][CB_PER]),
      .match_val(match_arr[c]), .hit(hit[c])
    );
  end

  // a clearing hit zeroes whichever counter the channel watches
  always_comb begin
    zero_req = '0;
    for (int n = 0; n < NCH; n++) begin
      if (hit[n] && ctrl_q[n][CB_CLR])
        zero_req[ctrl_q[n][CB_OWN] ? n : lead_of(n)] = 1'b1;
    end
  end

  logic [NCH-1:0] en_q, status_q, status_d, stat_clr;
  logic [W-1:0]   snap_q, snap_d;
  logic           en_we, snap_cap;
  logic [DW-1:0]  rdata_q, rdata_d;

  always_comb begin
    en_we    = wr_en && addr == A_EN;
    stat_clr = (wr_en && addr == A_STAT) ? wdata[EV_LSB +: NCH] : '0;
    status_d = (status_q & ~stat_clr) | (hit & en_q);
    snap_cap = rd_en && bank == BK_CNT && idx[2] && idx[0] && ctrl_q[idx][CB_SNAP];
    snap_d   = cnt_arr[idx - 3'd1];
    rdata_d  = '0;
    case (bank)
      BK_MATCH: rdata_d = DW'(match_arr[idx]);
      BK_CNT:   rdata_d = DW'(cnt_arr[idx]);
      BK_CTRL:  rdata_d = DW'(ctrl_q[idx]);
      default: begin
        if (addr == A_EN)        rdata_d = DW'(en_q) << EV_LSB;
        else if (addr == A_STAT) rdata_d = DW'(status_q) << EV_LSB;
        else if (addr == A_SNAP) rdata_d = DW'(snap_q);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      status_q <= '0;
      snap_q   <= '0;
      rdata_q  <= '0;
    end else begin
      if (en_we)    en_q   <= wdata[EV_LSB +: NCH];
      status_q <= status_d;
      if (snap_cap) snap_q <= snap_d;
      if (rd_en)    rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign irq   = |status_q;
endmodule

// File: rtl/xtmr_grp_chk.sv
module xtmr_grp_chk
  import xtmr_pkg::*;
#(
  parameter int W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NSRC-1:0]       tick_en,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [AW-1:0]         addr,
  input logic [DW-1:0]         wdata,
  input logic                  irq,
  input logic [NCH-1:0]        en_q,
  input logic [NCH-1:0]        status_q,
  input logic [W-1:0]          snap_q,
  input logic [NCH-1:0][W-1:0] cnt_arr
);
  // R2: no tick and no write means no counter moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_en) == '0 && !$past(wr_en)) |-> $stable(cnt_arr));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R2, R4, R10: a counter steps by one, clears to zero, or is loaded
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_arr[c] != $past(cnt_arr[c])) |->
        (cnt_arr[c] == $past(cnt_arr[c]) + W'(1) || cnt_arr[c] == '0 || $past(wr_en)));

    // R6: a status flag only rises with its enable set
    p_stat_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[c]) |-> $past(en_q[c]));

    // R6: a status flag only falls through a one written to it
    p_stat_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q[c]) |-> $past(wr_en && addr == A_STAT && wdata[EV_LSB + c]));
  end

  // R7: the interrupt only drops after a bus write
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en));

  // R8: the snapshot only moves on a read
  p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(snap_q));
endmodule

bind xtmr_grp xtmr_grp_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .irq(irq), .en_q(en_q), .status_q(status_q),
  .snap_q(snap_q), .cnt_arr(cnt_arr)
);

// File: tb/xtmr_grp_tb_top.sv
module xtmr_grp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick_en = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  xtmr_grp dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [9:0]  ctrl;
    logic [15:0] mt;
    logic [7:0]  n;
    logic [2:0]  src;
    logic [15:0] ec;
    logic        es;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{3'd0, 10'h000, 16'd5, 8'd3, 3'd0, 16'd3, 1'b0},
    '{3'd0, 10'h000, 16'd5, 8'd7, 3'd0, 16'd7, 1'b1},
    '{3'd2, 10'h000, 16'd4, 8'd6, 3'd0, 16'd6, 1'b1},
    '{3'd3, 10'h088, 16'd4, 8'd6, 3'd0, 16'd2, 1'b1},
    '{3'd1, 10'h082, 16'd9, 8'd5, 3'd2, 16'd5, 1'b0},
    '{3'd4, 10'h103, 16'd2, 8'd4, 3'd0, 16'd4, 1'b1},
    '{3'd6, 10'h005, 16'd1, 8'd4, 3'd5, 16'd0, 1'b0},
    '{3'd5, 10'h081, 16'd1, 8'd3, 3'd0, 16'd0, 1'b0}
  };
  string vtag [NV] = '{"R2", "R5", "R3", "R4", "R2", "R2", "R2", "R2"};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int src, input int n);
    if (n > 0) begin
      @(negedge clk); tick_en = 8'(1 << src);
      repeat (n) @(negedge clk);
      tick_en = '0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, counters stopped
    rd(5'd16, d); chk("R1 ctrl0", d, 0);
    rd(5'd8, d);  chk("R1 cnt0", d, 0);
    rd(5'd25, d); chk("R1 status", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    ticks(0, 3);
    rd(5'd8, d);  chk("R1 cnt0 stopped", d, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int lead, used;
      v = VT[i];
      lead = (v.ch < 4) ? 0 : (v.ch < 6) ? 4 : 6;
      used = v.ctrl[7] ? int'(v.ch) : lead;
      do_reset();
      wr(5'd24, 32'hFF0);
      if (used != int'(v.ch)) wr(5'(16 + lead), {29'b0, v.src});
      wr(5'(16 + v.ch), {22'b0, v.ctrl});
      wr(5'(v.ch), {16'b0, v.mt});
      ticks(int'(v.src), int'(v.n));
      rd(5'(8 + used), d);
      chk($sformatf("%s vec%0d count", vtag[i], i), d, {16'b0, v.ec});
      rd(5'd25, d);
      chk($sformatf("%s R6 vec%0d status", vtag[i], i), {31'b0, d[4 + v.ch]}, {31'b0, v.es});
    end

    // R3: non-lead without own bit latches no source
    do_reset();
    wr(5'd16, 32'h000);
    wr(5'd17, 32'h001);
    ticks(1, 3);
    rd(5'd8, d); chk("R3 cnt0 wrong src", d, 0);
    rd(5'd9, d); chk("R3 cnt1 no latch", d, 0);
    ticks(0, 2);
    rd(5'd8, d); chk("R3 cnt0 runs", d, 2);
    rd(5'd9, d); chk("R3 cnt1 idle", d, 0);

    // R5 one-shot with clear, then re-arm
    do_reset();
    wr(5'd24, 32'hFF0);
    wr(5'd16, 32'h088);
    wr(5'd0, 32'd3);
    ticks(0, 3);
    rd(5'd8, d);  chk("R4 cleared", d, 0);
    rd(5'd25, d); chk("R5 first hit", d, 32'h010);
    wr(5'd25, 32'h010);
    ticks(0, 3);
    rd(5'd8, d);  chk("R5 disarmed no clear", d, 3);
    rd(5'd25, d); chk("R5 disarmed no status", d, 0);
    wr(5'd8, 32'd0);
    wr(5'd0, 32'd3);
    ticks(0, 3);
    rd(5'd25, d); chk("R5 rearmed", d, 32'h010);

    // R5 periodic, R6 partial clear, R7 irq
    do_reset();
    wr(5'd24, 32'hFF0);
    wr(5'd16, 32'h0C8);
    wr(5'd0, 32'd3);
    ticks(0, 3);
    chk("R7 irq set", {31'b0, irq}, 1);
    wr(5'd25, 32'h020);
    rd(5'd25, d); chk("R6 other bit kept", d, 32'h010);
    chk("R7 irq kept", {31'b0, irq}, 1);
    wr(5'd25, 32'h010);
    chk("R7 irq cleared", {31'b0, irq}, 0);
    ticks(0, 3);
    rd(5'd25, d); chk("R5 periodic again", d, 32'h010);

    // R6 disabled channel sets no status
    do_reset();
    wr(5'd16, 32'h080);
    wr(5'd0, 32'd2);
    ticks(0, 2);
    rd(5'd25, d); chk("R6 no enable", d, 0);
    chk("R7 irq low", {31'b0, irq}, 0);
    rd(5'd8, d);  chk("R2 counts on", d, 2);

    // R8 snapshot
    do_reset();
    wr(5'd20, 32'h080);
    wr(5'd21, 32'h280);
    wr(5'd12, 32'd10);
    rd(5'd13, d);
    rd(5'd26, d); chk("R8 capture", d, 10);
    ticks(0, 2);
    rd(5'd26, d); chk("R8 hold", d, 10);
    rd(5'd13, d); chk("R2 cnt5 own", d, 2);
    rd(5'd26, d); chk("R8 recapture", d, 12);
    wr(5'd23, 32'h080);
    wr(5'd14, 32'd99);
    rd(5'd15, d);
    rd(5'd26, d); chk("R8 no snap bit", d, 12);

    // R9 control width, R10 count load
    wr(5'd17, 32'h3FF);
    rd(5'd17, d); chk("R9 lower width", d, 32'h0FF);
    wr(5'd21, 32'h3FF);
    rd(5'd21, d); chk("R9 upper width", d, 32'h3FF);
    wr(5'd10, 32'h1234);
    rd(5'd10, d); chk("R10 count load", d, 32'h1234);
    wr(5'd2, 32'h55);
    rd(5'd2, d);  chk("R10 match readback", d, 32'h55);

    report();
    $finish;
  end
endmodule